// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the device-side owner of a receive descriptor ring shared with a host. It holds a register file of descriptors. Each descriptor has a 16-bit status word, a 16-bit length and a 32-bit buffer address. The host fills descriptors and hands each one to the block by setting the EMPTY bit. For every completed incoming frame, the block writes the frame's length and status into the current descriptor. In the same cycle it clears EMPTY, which returns the descriptor to the host, and it moves to the next descriptor.

The ring has no fixed length in use. A descriptor whose WRAP bit is set sends the block back to index 0. The last physical entry wraps as well. The frame source delivers one pulse per finished frame, carrying the byte count without the 4-byte CRC and six error flags. If the current descriptor is still held by the host, the frame is dropped and a busy event is raised.

Two event bits, frame-written and busy, sit in an event register. The host acknowledges them by writing ones to clear them. An interrupt line is active while any event is set whose mask bit is also set.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset, the ring index is 0, every descriptor field reads 0, the events and the mask are 0, and `irq` is low.
- R2: A frame (`frm_valid` high) on a current descriptor with EMPTY (status bit 15) set writes that descriptor as follows:
  - EMPTY is cleared.
  - WRAP (bit 13) and INTR (bit 12) keep their old values.
  - LAST (bit 11) and FIRST (bit 10) are set.
  - MISS (bit 8) is written 0.
  - Status bits [5:0] take `frm_err` = {long, non-octet, short, CRC, overrun, collision} (bit 5 first).
  - The buffer address is left unchanged.
- R3: After an accepted frame, the index becomes 0 if the descriptor's WRAP bit was set or the index was `N_DESC-1`; otherwise it increments by one. It does not move without an accepted frame.
- R4: The written length is `frm_len+4`. Length and status are both visible through the host read port one clock after the `frm_valid` cycle, together with EMPTY cleared.
- R5: An accepted frame sets event bit 0 (frame written).
- R6: A frame arriving while the current descriptor has EMPTY clear leaves every descriptor and the index unchanged and sets event bit 1 (busy).
- R7: A host write (`hd_wr_en`) replaces status, length and address of descriptor `hd_wr_idx`. These fields read back through `hd_rd_idx`.
- R8: Writing `ev_clr_en` with `ev_clr_data` clears each event bit written as one. An event that is raised in the same cycle stays set.
- R9: `irq` is the OR of `ev_q & mask_q`. `mask_wr_en` loads `mask_q` from `mask_wr_data`.
- R10: The buffer limit is `MAX_FRAME+4` rounded up to a multiple of 32 (1536 by default). When `frm_len+4` exceeds this limit, the length is written as the limit and status bit 5 (long) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | One-cycle pulse: a frame has completed |
| frm_len | input | 16 | Frame byte count without CRC |
| frm_err | input | 6 | Error flags {long, non-octet, short, CRC, overrun, collision} |
| hd_wr_en | input | 1 | Host descriptor write strobe |
| hd_wr_idx | input | IDX_W | Descriptor index for host write |
| hd_wr_status | input | 16 | Status word to write |
| hd_wr_len | input | 16 | Length to write |
| hd_wr_addr | input | 32 | Buffer address to write |
| hd_rd_idx | input | IDX_W | Descriptor index for host read |
| hd_rd_status | output | 16 | Status of the read descriptor |
| hd_rd_len | output | 16 | Length of the read descriptor |
| hd_rd_addr | output | 32 | Buffer address of the read descriptor |
| ev_clr_en | input | 1 | Event acknowledge strobe |
| ev_clr_data | input | 2 | Ones clear the matching event bits |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_data | input | 2 | New mask value |
| ev_q | output | 2 | Events: bit 0 frame written, bit 1 busy |
| mask_q | output | 2 | Current mask |
| irq | output | 1 | Masked event OR |
| rx_idx | output | IDX_W | Current ring index |

## Verification
Directed cases cover the following:
- A frame arriving before any descriptor is released, which separates drop-and-busy from accept.
- A ring shortened by a WRAP mark, contrasted with a ring with no marks that wraps on the last entry.
- Lengths just at and just past the buffer limit, which show where truncation starts.
- An acknowledge coinciding with a new event.

A seeded random mix then interleaves host releases, some of which move the WRAP mark, frames with random lengths and error flags, and partial acknowledges. This shows whether ownership, index order and event bits stay consistent with a bench model over long runs. Mask changes with events pending separate the interrupt gating from the raw event state.

// File: rtl/rxd_pkg.sv
// Shared widths, status bit positions and descriptor type for the receive
// descriptor ring writer. Assumes 16-bit status and length words.
package rxd_pkg;
    localparam int ST_W   = 16;
    localparam int LEN_W  = 16;
    localparam int ADDR_W = 32;
    localparam int ERR_W  = 6;
    localparam int EV_W   = 2;

    // Status bit positions; the host decodes these.
    localparam int ST_EMPTY = 15;
    localparam int ST_WRAP  = 13;
    localparam int ST_INTR  = 12;
    localparam int ST_LAST  = 11;
    localparam int ST_FIRST = 10;
    localparam int ST_MISS  = 8;
    localparam int ST_LONG  = 5;

    // Event bit positions.
    localparam int EV_RXF = 0;
    localparam int EV_BSY = 1;

    typedef struct packed {
        logic [ST_W-1:0]   status;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] addr;
    } desc_t;
endpackage

// File: rtl/rxd_desc_file.sv
// Descriptor register file. Holds N_DESC descriptors, with one host write port
// and one engine write-back port. The engine port updates status and length
// only and wins over a host write to the same entry. Two asynchronous read
// ports: the engine's current entry and a host read index.
module rxd_desc_file
    import rxd_pkg::*;
#(
    parameter int N_DESC = 128,
    localparam int IDX_W = (N_DESC > 1) ? $clog2(N_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  desc_t             host_desc,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic [ST_W-1:0]   eng_status,
    input  logic [LEN_W-1:0]  eng_len,
    input  logic [IDX_W-1:0]  cur_idx,
    output desc_t             cur_desc,
    input  logic [IDX_W-1:0]  rd_idx,
    output desc_t             rd_desc
);
    desc_t ring [N_DESC];

    // Update entries: reset to zero, engine write-back first, else host write.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_DESC; i++) begin
            if (!rst_n) begin
                ring[i] <= '0;
            end else if (eng_we && (eng_idx == IDX_W'(i))) begin
                ring[i].status <= eng_status;
                ring[i].len    <= eng_len;
            end else if (host_we && (host_idx == IDX_W'(i))) begin
                ring[i] <= host_desc;
            end
        end
    end

    // Read ports.
    assign cur_desc = ring[cur_idx];
    assign rd_desc  = ring[rd_idx];

    // R4: a written-back entry is host-owned on the next cycle.
    p_wb_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |=> !ring[$past(eng_idx)].status[ST_EMPTY])
        else $error("R4 write-back left EMPTY set");

    // R2: write-back never touches the buffer address.
    p_addr_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && !(host_we && host_idx == eng_idx)) |=>
            $stable(ring[$past(eng_idx)].addr))
        else $error("R2 buffer address changed by write-back");
endmodule

// File: rtl/rxd_engine.sv
// Frame acceptance engine. On a frame pulse, it checks ownership of the
// current descriptor. If it owns it, it builds the write-back status and
// length (truncating to the buffer limit) and moves the ring index. If not,
// it drops the frame and reports busy. Assumes one frame per pulse.
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int N_DESC    = 128,
    parameter int MAX_FRAME = 1514,
    localparam int IDX_W    = (N_DESC > 1) ? $clog2(N_DESC) : 1,
    localparam int BUF_LIM  = ((MAX_FRAME + 4 + 31) / 32) * 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [ERR_W-1:0]  frm_err,
    input  desc_t             cur_desc,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              eng_we,
    output logic [ST_W-1:0]   eng_status,
    output logic [LEN_W-1:0]  eng_len,
    output logic              set_rxf,
    output logic              set_bsy
);
    localparam logic [LEN_W:0] LIM_X = (LEN_W+1)'(BUF_LIM);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DESC - 1);

    logic              owned;
    logic [LEN_W:0]    len_crc;
    logic              trunc;
    logic [IDX_W-1:0]  nxt_idx;

    // Ownership test and event requests.
    always_comb begin
        owned   = cur_desc.status[ST_EMPTY];
        eng_we  = frm_valid && owned;
        set_rxf = frm_valid && owned;
        set_bsy = frm_valid && !owned;
    end

    // Length with CRC, clipped to the buffer limit.
    always_comb begin
        len_crc = {1'b0, frm_len} + (LEN_W+1)'(4);
        trunc   = len_crc > LIM_X;
        eng_len = trunc ? LIM_X[LEN_W-1:0] : len_crc[LEN_W-1:0];
    end

    // Write-back status word.
    always_comb begin
        eng_status           = '0;
        eng_status[ST_WRAP]  = cur_desc.status[ST_WRAP];
        eng_status[ST_INTR]  = cur_desc.status[ST_INTR];
        eng_status[ST_FIRST] = 1'b1;
        eng_status[ST_LAST]  = 1'b1;
        eng_status[ST_MISS]  = 1'b0;
        eng_status[ERR_W-1:0] = frm_err;
        if (trunc) eng_status[ST_LONG] = 1'b1;
    end

    // Next index: wrap on mark or on last entry.
    always_comb begin
        if (cur_desc.status[ST_WRAP] || (cur_idx == LAST_IDX))
            nxt_idx = '0;
        else
            nxt_idx = cur_idx + IDX_W'(1);
    end

    // Ring index register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_idx <= '0;
        else if (eng_we)
            cur_idx <= nxt_idx;
    end

    // R3: the index stays put without a frame.
    p_idx_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> $stable(cur_idx))
        else $error("R3 index moved without a frame");

    // R6: a frame on a host-held descriptor does not move the index.
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_bsy |=> $stable(cur_idx))
        else $error("R6 index moved on busy drop");

    // R10: the written length never exceeds the buffer limit.
    p_len_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> ({1'b0, eng_len} <= LIM_X))
        else $error("R10 length above buffer limit");
endmodule

// File: rtl/rxd_events.sv
// Event and mask registers. Event bits are set by the engine and cleared by
// write-one-to-clear acknowledges; a set wins over a clear in the same cycle.
// The interrupt is the OR of masked events.
module rxd_events
    import rxd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_rxf,
    input  logic            set_bsy,
    input  logic            clr_en,
    input  logic [EV_W-1:0] clr_data,
    input  logic            mask_we,
    input  logic [EV_W-1:0] mask_data,
    output logic [EV_W-1:0] ev_q,
    output logic [EV_W-1:0] mask_q,
    output logic            irq
);
    logic [EV_W-1:0] set_vec;
    logic [EV_W-1:0] clr_vec;

    // Gather set and clear requests.
    always_comb begin
        set_vec         = '0;
        set_vec[EV_RXF] = set_rxf;
        set_vec[EV_BSY] = set_bsy;
        clr_vec         = clr_en ? clr_data : '0;
    end

    // Event register, set over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ~clr_vec) | set_vec;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_data;
    end

    // Interrupt output.
    assign irq = |(ev_q & mask_q);

    // R8: an acknowledged bit with no new event is clear next cycle.
    p_w1c_rxf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_data[EV_RXF] && !set_rxf) |=> !ev_q[EV_RXF])
        else $error("R8 frame event not cleared");

    // R8: a raised event is always visible next cycle.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_bsy |=> ev_q[EV_BSY])
        else $error("R8 busy event lost");

    // R9: no interrupt while fully masked.
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq)
        else $error("R9 interrupt with zero mask");
endmodule

// File: rtl/rxd_ring_writer.sv
// Top of the receive descriptor ring writer. It ties the descriptor file,
// the acceptance engine and the event registers together. The host sees
// descriptors through plain read and write ports and sees events through the
// write-one-to-clear port and the interrupt.
module rxd_ring_writer
    import rxd_pkg::*;
#(
    parameter int N_DESC    = 128,
    parameter int MAX_FRAME = 1514,
    localparam int IDX_W    = (N_DESC > 1) ? $clog2(N_DESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [15:0]       frm_len,
    input  logic [5:0]        frm_err,
    input  logic              hd_wr_en,
    input  logic [IDX_W-1:0]  hd_wr_idx,
    input  logic [15:0]       hd_wr_status,
    input  logic [15:0]       hd_wr_len,
    input  logic [31:0]       hd_wr_addr,
    input  logic [IDX_W-1:0]  hd_rd_idx,
    output logic [15:0]       hd_rd_status,
    output logic [15:0]       hd_rd_len,
    output logic [31:0]       hd_rd_addr,
    input  logic              ev_clr_en,
    input  logic [1:0]        ev_clr_data,
    input  logic              mask_wr_en,
    input  logic [1:0]        mask_wr_data,
    output logic [1:0]        ev_q,
    output logic [1:0]        mask_q,
    output logic              irq,
    output logic [IDX_W-1:0]  rx_idx
);
    desc_t             host_desc;
    desc_t             cur_desc;
    desc_t             rd_desc;
    logic              eng_we;
    logic [ST_W-1:0]   eng_status;
    logic [LEN_W-1:0]  eng_len;
    logic              set_rxf;
    logic              set_bsy;

    // Pack the host write fields.
    assign host_desc = '{status: hd_wr_status, len: hd_wr_len, addr: hd_wr_addr};

    rxd_desc_file #(.N_DESC(N_DESC)) u_file (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (hd_wr_en),
        .host_idx   (hd_wr_idx),
        .host_desc  (host_desc),
        .eng_we     (eng_we),
        .eng_idx    (rx_idx),
        .eng_status (eng_status),
        .eng_len    (eng_len),
        .cur_idx    (rx_idx),
        .cur_desc   (cur_desc),
        .rd_idx     (hd_rd_idx),
        .rd_desc    (rd_desc)
    );

    rxd_engine #(.N_DESC(N_DESC), .MAX_FRAME(MAX_FRAME)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_valid  (frm_valid),
        .frm_len    (frm_len),
        .frm_err    (frm_err),
        .cur_desc   (cur_desc),
        .cur_idx    (rx_idx),
        .eng_we     (eng_we),
        .eng_status (eng_status),
        .eng_len    (eng_len),
        .set_rxf    (set_rxf),
        .set_bsy    (set_bsy)
    );

    rxd_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_rxf   (set_rxf),
        .set_bsy   (set_bsy),
        .clr_en    (ev_clr_en),
        .clr_data  (ev_clr_data),
        .mask_we   (mask_wr_en),
        .mask_data (mask_wr_data),
        .ev_q      (ev_q),
        .mask_q    (mask_q),
        .irq       (irq)
    );

    // Host read fields.
    assign hd_rd_status = rd_desc.status;
    assign hd_rd_len    = rd_desc.len;
    assign hd_rd_addr   = rd_desc.addr;

    // R5: an accepted frame shows its event next cycle.
    p_rxf_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_rxf |=> ev_q[EV_RXF])
        else $error("R5 frame event missing");
endmodule

// File: tb/test_rxd_ring_writer.sv
module test_rxd_ring_writer;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int MAXF       = 1514;
    localparam int LIM        = ((MAXF + 4 + 31) / 32) * 32;
    localparam int IW         = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_valid = 1'b0;
    logic [15:0] frm_len = '0;
    logic [5:0]  frm_err = '0;
    logic hd_wr_en = 1'b0;
    logic [IW-1:0] hd_wr_idx = '0;
    logic [15:0] hd_wr_status = '0, hd_wr_len = '0;
    logic [31:0] hd_wr_addr = '0;
    logic [IW-1:0] hd_rd_idx = '0;
    logic [15:0] hd_rd_status, hd_rd_len;
    logic [31:0] hd_rd_addr;
    logic ev_clr_en = 1'b0;
    logic [1:0] ev_clr_data = '0;
    logic mask_wr_en = 1'b0;
    logic [1:0] mask_wr_data = '0;
    logic [1:0] ev_q, mask_q;
    logic irq;
    logic [IW-1:0] rx_idx;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] m_st [N];
    logic [15:0] m_len [N];
    logic [31:0] m_addr [N];
    int m_idx = 0;
    logic [1:0] m_ev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxd_ring_writer #(.N_DESC(N), .MAX_FRAME(MAXF)) i_rxd_ring_writer (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
        .frm_err(frm_err), .hd_wr_en(hd_wr_en), .hd_wr_idx(hd_wr_idx),
        .hd_wr_status(hd_wr_status), .hd_wr_len(hd_wr_len), .hd_wr_addr(hd_wr_addr),
        .hd_rd_idx(hd_rd_idx), .hd_rd_status(hd_rd_status), .hd_rd_len(hd_rd_len),
        .hd_rd_addr(hd_rd_addr), .ev_clr_en(ev_clr_en), .ev_clr_data(ev_clr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data), .ev_q(ev_q),
        .mask_q(mask_q), .irq(irq), .rx_idx(rx_idx)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_len(int len);
        return (len + 4 > LIM) ? 16'(LIM) : 16'(len + 4);
    endfunction

    function automatic logic [15:0] exp_st(logic [15:0] old, int len, logic [5:0] err);
        logic [15:0] s = '0;
        s[13] = old[13];
        s[12] = old[12];
        s[11] = 1'b1;
        s[10] = 1'b1;
        s[5:0] = err;
        if (len + 4 > LIM) s[5] = 1'b1;
        return s;
    endfunction

    task automatic host_put(int idx, logic [15:0] st, logic [31:0] addr);
        @(negedge clk);
        hd_wr_en = 1'b1; hd_wr_idx = IW'(idx);
        hd_wr_status = st; hd_wr_len = '0; hd_wr_addr = addr;
        @(negedge clk);
        hd_wr_en = 1'b0;
        m_st[idx] = st; m_len[idx] = '0; m_addr[idx] = addr;
    endtask

    task automatic send(int len, logic [5:0] err);
        @(negedge clk);
        frm_valid = 1'b1; frm_len = 16'(len); frm_err = err;
        @(negedge clk);
        frm_valid = 1'b0;
        if (m_st[m_idx][15]) begin
            m_len[m_idx] = exp_len(len);
            m_st[m_idx]  = exp_st(m_st[m_idx], len, err);
            m_ev[0] = 1'b1;
            m_idx = (m_st[m_idx][13] || m_idx == N-1) ? 0 : m_idx + 1;
        end else begin
            m_ev[1] = 1'b1;
        end
    endtask

    task automatic ev_ack(logic [1:0] d);
        @(negedge clk);
        ev_clr_en = 1'b1; ev_clr_data = d;
        @(negedge clk);
        ev_clr_en = 1'b0;
        m_ev = m_ev & ~d;
    endtask

    task automatic check_desc(string req, int idx);
        hd_rd_idx = IW'(idx);
        #1;
        chk(req, {48'd0, hd_rd_status}, {48'd0, m_st[idx]});
        chk(req, {48'd0, hd_rd_len}, {48'd0, m_len[idx]});
        chk(req, {32'd0, hd_rd_addr}, {32'd0, m_addr[idx]});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int w;
        for (int i = 0; i < N; i++) begin m_st[i] = '0; m_len[i] = '0; m_addr[i] = '0; end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 idx", 64'(rx_idx), 0);
        chk("R1 ev", 64'(ev_q), 0);
        chk("R1 mask", 64'(mask_q), 0);
        chk("R1 irq", 64'(irq), 0);
        for (int i = 0; i < N; i++) check_desc("R1 desc", i);

        // R6: frame before any release is dropped
        send(100, 6'h0);
        chk("R6 idx", 64'(rx_idx), 0);
        chk("R6 ev busy", 64'(ev_q), 64'(m_ev));
        check_desc("R6 desc untouched", 0);

        // R8: acknowledge busy
        ev_ack(2'b10);
        chk("R8 cleared", 64'(ev_q), 0);

        // R7: release descriptors, wrap mark on 4
        for (int i = 0; i < N; i++)
            host_put(i, (i == 4) ? 16'hB000 : 16'h9000, 32'h1000_0000 + 32'(i) * 32'h600);
        for (int i = 0; i < N; i++) check_desc("R7 host write", i);

        // R2 R4 R5: first accepted frame
        send(60, 6'b000100);
        check_desc("R2 R4 write-back", 0);
        chk("R3 step", 64'(rx_idx), 1);
        chk("R5 rxf", 64'(ev_q), 64'(m_ev));

        // R10: exact limit and one past
        send(LIM - 4, 6'h0);
        check_desc("R10 at limit", 1);
        chk("R10 no long", 64'(hd_rd_status[5]), 0);
        send(LIM - 3, 6'h0);
        check_desc("R10 truncated", 2);
        chk("R10 long set", 64'(hd_rd_status[5]), 1);
        chk("R10 len", 64'(hd_rd_len), 64'(LIM));

        // R3: wrap mark on 4
        send(200, 6'h0);
        send(300, 6'h3);
        chk("R3 wrap mark", 64'(rx_idx), 0);
        check_desc("R2 wrap kept", 4);

        // R9: mask gating
        @(negedge clk); mask_wr_en = 1'b1; mask_wr_data = 2'b00;
        @(negedge clk); mask_wr_en = 1'b0;
        chk("R9 masked off", 64'(irq), 0);
        @(negedge clk); mask_wr_en = 1'b1; mask_wr_data = 2'b01;
        @(negedge clk); mask_wr_en = 1'b0;
        chk("R9 mask q", 64'(mask_q), 1);
        chk("R9 irq on", 64'(irq), 1);
        ev_ack(2'b01);
        chk("R9 irq off", 64'(irq), 0);

        // R8: set and clear in same cycle, set wins (desc 0 not released)
        @(negedge clk);
        frm_valid = 1'b1; frm_len = 16'd10; ev_clr_en = 1'b1; ev_clr_data = 2'b10;
        @(negedge clk);
        frm_valid = 1'b0; ev_clr_en = 1'b0;
        m_ev[1] = 1'b1;
        chk("R8 set wins", 64'(ev_q[1]), 1);
        chk("R6 idx hold", 64'(rx_idx), 0);
        ev_ack(2'b11);

        // R3: no marks, wrap at N-1
        for (int i = 0; i < N; i++) host_put(i, 16'h8000, 32'(i) * 32'h40);
        for (int i = 0; i < N; i++) send(64 + i, 6'h0);
        chk("R3 last entry wrap", 64'(rx_idx), 0);
        check_desc("R2 last entry", N - 1);

        // Random mix
        for (int it = 0; it < 600; it++) begin
            w = $urandom % 10;
            if (w < 4) begin
                int k = $urandom % N;
                host_put(k, (($urandom % 6) == 0) ? 16'hB000 : 16'h9000, $urandom);
                check_desc("R7 random host", k);
            end else if (w < 9) begin
                int pidx = m_idx;
                int ln = $urandom % 1600;
                logic [5:0] er = (($urandom % 4) == 0) ? 6'($urandom) : 6'h0;
                send(ln, er);
                chk("R3 random idx", 64'(rx_idx), 64'(m_idx));
                chk("R5 R6 random ev", 64'(ev_q), 64'(m_ev));
                check_desc("R2 random desc", pidx);
            end else begin
                logic [1:0] d = 2'($urandom);
                ev_ack(d);
                chk("R8 random ack", 64'(ev_q), 64'(m_ev));
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule